// File: doc/BRIEF.md
# Serial Configuration Loader for a Dual Frequency Synthesizer

This block is the configuration port of a two-channel frequency synthesizer. Software-side logic writes it over three wires: a serial clock, a serial data line and a load strobe. Each frame is 22 bits long and is sent most significant bit first. Bits are shifted into a holding register on the rising edge of the serial clock. The two bits received last form a destination code.

When the load strobe rises, the code picks one of four destination latches. The remaining 20 bits of the frame are copied into that latch. The latches drive the synthesizer channels directly:
- the divide word for each channel,
- the reference divide word and a 5-bit mode field for each channel,
- a prescaler-select bit and a power-down bit for each channel.

The three serial lines are asynchronous to the system clock. Each line passes through a two-stage synchroniser, and the edges of the serial clock and of the load strobe are detected in the system clock domain.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset, every latch output is zero, except `hf_pd` and `lf_pd`, which are 1.
- R2: On each rising edge of `ser_clk` while `ser_load` is low, the holding register shifts left by one bit and takes `ser_data` into bit 0. After 22 edges, the first bit sent sits in frame bit 21.
- R3: When the load strobe rises and frame bits [1:0] are 11, the high-band divide latch takes its fields from the frame:
  - `hf_n` = bits [19:2]
  - `hf_psel` = bit 20
  - `hf_pd` = bit 21
- R4: When the load strobe rises and the code is 10, the low-band divide latch takes its fields from the frame, and bits [21:19] are ignored:
  - `lf_n` = bits [16:2]
  - `lf_psel` = bit 17
  - `lf_pd` = bit 18
- R5: When the load strobe rises and the code is 01, `hf_r` takes frame bits [16:2] and `hf_mode` takes bits [21:17].
- R6: When the load strobe rises and the code is 00, `lf_r` takes frame bits [16:2] and `lf_mode` takes bits [21:17].
- R7: Latches change only on a rising edge of the load strobe, and only the addressed latch changes. Shifting a frame in leaves all outputs unchanged.
- R8: Rising edges of `ser_clk` are ignored while `ser_load` is high. A load does not clear the holding register, so a second strobe with no new shifting loads the same frame again.
- R9: If more than 22 bits are shifted in before a load, only the last 22 bits received are kept.
- R10: Each serial input passes through two synchroniser stages. A latch output changes on the third rising edge of `clk` after `ser_load` goes high at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Load strobe; its rising edge transfers the frame |
| hf_n | output | 18 | High-band divide word |
| hf_psel | output | 1 | High-band prescaler select |
| hf_pd | output | 1 | High-band power-down |
| lf_n | output | 15 | Low-band divide word |
| lf_psel | output | 1 | Low-band prescaler select |
| lf_pd | output | 1 | Low-band power-down |
| hf_r | output | 15 | High-band reference divide word |
| hf_mode | output | 5 | High-band mode field |
| lf_r | output | 15 | Low-band reference divide word |
| lf_mode | output | 5 | Low-band mode field |

## Verification
An input level is seen by the edge logic two system clocks after it is applied. The holding register or the addressed latch therefore changes on the third clock edge after a serial clock or load strobe rises.

The bench holds every serial level for at least three system clocks, so no edge is missed or merged. It samples outputs at the falling system clock edge. A behavioural model delays the sampled inputs through a three-entry queue and is compared with every output on every cycle. Directed checks run four cycles after each strobe falls, by which time each load has long settled.

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader #(
  parameter int SR_W   = 22,
  parameter int HFN_W  = 18,
  parameter int LFN_W  = 15,
  parameter int REF_W  = 15,
  parameter int MODE_W = 5,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  output logic [HFN_W-1:0]  hf_n,
  output logic              hf_psel,
  output logic              hf_pd,
  output logic [LFN_W-1:0]  lf_n,
  output logic              lf_psel,
  output logic              lf_pd,
  output logic [REF_W-1:0]  hf_r,
  output logic [MODE_W-1:0] hf_mode,
  output logic [REF_W-1:0]  lf_r,
  output logic [MODE_W-1:0] lf_mode
);
  localparam int PAY_W = SR_W - 2;

  logic [SYNC_N:0] clk_p, dat_p, ld_p;
  logic [SR_W-1:0] sr;
  logic            sclk_rise, ld_high, ld_rise;
  logic [PAY_W-1:0] pay;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_p <= '0;
      dat_p <= '0;
      ld_p  <= '0;
    end else begin
      clk_p <= {clk_p[SYNC_N-1:0], ser_clk};
      dat_p <= {dat_p[SYNC_N-1:0], ser_data};
      ld_p  <= {ld_p[SYNC_N-1:0], ser_load};
    end

  assign ld_high   = ld_p[SYNC_N-1];
  assign ld_rise   = ld_high & ~ld_p[SYNC_N];
  assign sclk_rise = clk_p[SYNC_N-1] & ~clk_p[SYNC_N] & ~ld_high;
  assign pay       = sr[SR_W-1:2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         sr <= '0;
    else if (sclk_rise) sr <= {sr[SR_W-2:0], dat_p[SYNC_N-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hf_n <= '0; hf_psel <= 1'b0; hf_pd <= 1'b1;
      lf_n <= '0; lf_psel <= 1'b0; lf_pd <= 1'b1;
      hf_r <= '0; hf_mode <= '0;
      lf_r <= '0; lf_mode <= '0;
    end else if (ld_rise) begin
      case (sr[1:0])
        2'b11: begin
          hf_n    <= pay[HFN_W-1:0];
          hf_psel <= pay[HFN_W];
          hf_pd   <= pay[HFN_W+1];
        end
        2'b10: begin
          lf_n    <= pay[LFN_W-1:0];
          lf_psel <= pay[LFN_W];
          lf_pd   <= pay[LFN_W+1];
        end
        2'b01: begin
          hf_r    <= pay[REF_W-1:0];
          hf_mode <= pay[REF_W +: MODE_W];
        end
        default: begin
          lf_r    <= pay[REF_W-1:0];
          lf_mode <= pay[REF_W +: MODE_W];
        end
      endcase
    end

  a_r8_hold_during_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_high && ld_p[SYNC_N]) |=> $stable(sr));

  a_r7_no_load_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> ($stable(hf_n) && $stable(hf_psel) && $stable(hf_pd) &&
                  $stable(lf_n) && $stable(lf_psel) && $stable(lf_pd) &&
                  $stable(hf_r) && $stable(hf_mode) && $stable(lf_r) && $stable(lf_mode)));

  a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise |=> $countones({!$stable({hf_n, hf_psel, hf_pd}), !$stable({lf_n, lf_psel, lf_pd}),
                            !$stable({hf_r, hf_mode}), !$stable({lf_r, lf_mode})}) <= 1);

  a_r3_hf_divide_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && sr[1:0] == 2'b11) |=> (hf_n == $past(sr[HFN_W+1:2])));

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> (sr[SR_W-1:1] == $past(sr[SR_W-2:0])));
endmodule

// File: tb/synth_cfg_loader_bench.sv
module synth_cfg_loader_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [17:0] hf_n; logic hf_psel, hf_pd;
  logic [14:0] lf_n; logic lf_psel, lf_pd;
  logic [14:0] hf_r, lf_r; logic [4:0] hf_mode, lf_mode;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_loader u_synth_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .hf_n(hf_n), .hf_psel(hf_psel), .hf_pd(hf_pd),
    .lf_n(lf_n), .lf_psel(lf_psel), .lf_pd(lf_pd),
    .hf_r(hf_r), .hf_mode(hf_mode), .lf_r(lf_r), .lf_mode(lf_mode));

  // reference model: inputs seen by the edge logic two clocks late
  logic qc[$], qd[$], ql[$];
  logic [21:0] m_sr;
  logic [76:0] m_out;

  function automatic logic [76:0] reset_vals();
    return {18'h0, 1'b0, 1'b1, 15'h0, 1'b0, 1'b1, 15'h0, 5'h0, 15'h0, 5'h0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      qc = '{0, 0, 0}; qd = '{0, 0, 0}; ql = '{0, 0, 0};
      m_sr = '0; m_out = reset_vals();
    end else begin
      if (ql[1] && !ql[0]) begin
        case (m_sr[1:0])
          2'b11: m_out[76:57] = {m_sr[19:2], m_sr[20], m_sr[21]};
          2'b10: m_out[56:40] = {m_sr[16:2], m_sr[17], m_sr[18]};
          2'b01: m_out[39:20] = {m_sr[16:2], m_sr[21:17]};
          default: m_out[19:0] = {m_sr[16:2], m_sr[21:17]};
        endcase
      end else if (qc[1] && !qc[0] && !ql[1]) begin
        m_sr = {m_sr[20:0], qd[1]};
      end
      qc.push_back(ser_clk); void'(qc.pop_front());
      qd.push_back(ser_data); void'(qd.pop_front());
      ql.push_back(ser_load); void'(ql.pop_front());
    end
  end

  function automatic logic [76:0] dut_out();
    return {hf_n, hf_psel, hf_pd, lf_n, lf_psel, lf_pd, hf_r, hf_mode, lf_r, lf_mode};
  endfunction

  task automatic chk(input string tag, input logic [76:0] act, input logic [76:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && !done) chk("R10 per-cycle model", dut_out(), m_out);

  task automatic send_bit(input logic b);
    @(negedge clk) ser_data = b;
    repeat (3) @(negedge clk); ser_clk = 1'b1;
    repeat (3) @(negedge clk); ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [21:0] w);
    for (int i = 21; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic strobe();
    repeat (2) @(negedge clk); ser_load = 1'b1;
    repeat (4) @(negedge clk); ser_load = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  logic [21:0] fa, fb, fc, fd, fe, ff;

  initial begin
    fa = {1'b0, 1'b1, 18'h2A5C3, 2'b11};
    fb = {3'b111, 1'b0, 1'b1, 15'h5A3C, 2'b10};
    fc = {5'h13, 15'h1234, 2'b01};
    fd = {5'h0A, 15'h7ABC, 2'b00};
    fe = {1'b1, 1'b0, 18'h1F00F, 2'b11};
    ff = {5'h15, 15'h0F0F, 2'b00};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset values", dut_out(), reset_vals());

    send_word(fa); strobe();
    chk("R3 hf_n", hf_n, 18'h2A5C3);
    chk("R3 hf_psel", hf_psel, 1'b1);
    chk("R3 hf_pd", hf_pd, 1'b0);
    chk("R7 lf_pd untouched", lf_pd, 1'b1);

    send_word(fb); strobe();
    chk("R4 lf_n", lf_n, 15'h5A3C);
    chk("R4 lf_psel/pd", {lf_psel, lf_pd}, 2'b10);
    chk("R7 hf_n untouched", hf_n, 18'h2A5C3);

    send_word(fc); strobe();
    chk("R5 hf_r", hf_r, 15'h1234);
    chk("R5 hf_mode", hf_mode, 5'h13);

    send_word(fd); strobe();
    chk("R6 lf_r", lf_r, 15'h7ABC);
    chk("R6 lf_mode", lf_mode, 5'h0A);

    send_word(fe);
    repeat (6) @(negedge clk);
    chk("R7 shift alone keeps hf_n", hf_n, 18'h2A5C3);
    strobe();
    chk("R2 msb-first hf_n", hf_n, 18'h1F00F);
    chk("R2 msb-first hf_psel/pd", {hf_psel, hf_pd}, 2'b01);

    // clock pulses while the strobe is high must not alter the holding register
    repeat (2) @(negedge clk); ser_load = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      ser_data = 1'b0;
      repeat (3) @(negedge clk); ser_clk = 1'b1;
      repeat (3) @(negedge clk); ser_clk = 1'b0;
    end
    repeat (3) @(negedge clk); ser_load = 1'b0;
    repeat (4) @(negedge clk);
    strobe();
    chk("R8 reload same frame hf_n", hf_n, 18'h1F00F);
    chk("R8 reload same frame hf_pd", hf_pd, 1'b1);

    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_word(ff); strobe();
    chk("R9 last 22 kept lf_r", lf_r, 15'h0F0F);
    chk("R9 last 22 kept lf_mode", lf_mode, 5'h15);
    chk("R9 hf_r untouched", hf_r, 15'h1234);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    checks++; fails++;
    $display("FAIL R10 watchdog expired actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule